// File: doc/BRIEF.md
# Addressed Serial Display-Data Receiver

This block takes display and control data from a host controller over a three-wire serial link: a frame-select line, a serial clock and a data line. A transfer opens when the frame select goes high. The first eight bits form a device address. A transfer whose address is not the block's own is ignored for its whole length. After a matching address, the host sends 64-bit words. Each word carries a 52-bit slice of a 204-bit display image and a trailer. The trailer's last two bits tell the block which slice the word belongs to. The first slice also carries eight control bits.

All three serial inputs pass through two-flop synchronisers into a fast system clock, and edges are found in that domain. Completed words wait in a staging area. When the frame select falls, the block copies every staged word into the visible registers in a single cycle. A host driving a small panel may send only the first word, or a few words in any order. Slices it leaves out keep their old contents. A trailing word that was cut short is thrown away. A transfer that lacks word 0 changes nothing. After reset the control register holds power-saving on and segments off, so the downstream drivers show nothing until the host has loaded real data.

Top module: `seg_frame_rx`

## Requirements
- R1: After reset `dispOut` is all zeros and `ctrlOut` is 0xC0 (bit 7 power saving set, bit 6 segments off set, all other bits clear).
- R2: The first 8 bits after `ceIn` rises form the address, least significant bit first. Unless it equals 0x41, neither output changes for that transfer.
- R3: A data bit is taken from `sdIn` on each rising edge of `sclkIn` while `ceIn` is high. Transfers work both when `sclkIn` idles low and when it idles high. When it idles high, the level present as `ceIn` rises is not an edge.
- R4: After the address, bit k of a word is the k-th bit received (k = 0..63). Bits 0..51 are a display slice. The word index is {bit 63, bit 62}. Index i writes `dispOut[52*i + j]` from bit j. Index 3 uses only bits 0..47.
- R5: In word index 0, bits 52..59 load `ctrlOut[7:0]` in that order: bit 0 low-current, bits 4..1 port-select count, bit 5 half bias, bit 6 segments off, bit 7 power saving. Bits 60 and 61 are ignored.
- R6: The outputs change only as a direct result of `ceIn` falling. Every staged word appears at the same time, a few system clocks after the fall.
- R7: A word with fewer than 64 bits received when `ceIn` falls is dropped. Complete words in the same transfer are still applied.
- R8: A transfer that delivers no complete word with index 0 changes neither output.
- R9: Slices with no complete word in a transfer keep their previous values.
- R10: Words may come in any order; the index alone picks the slice. If an index repeats, the last complete word with that index wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclkIn` |
| rstN | input | 1 | Active-low asynchronous reset |
| ceIn | input | 1 | Frame select, high while a transfer is in progress |
| sclkIn | input | 1 | Serial bit clock, may idle at either level |
| sdIn | input | 1 | Serial data, sampled on rising `sclkIn` |
| dispOut | output | 204 | Display image, bit 0 is the first display bit |
| ctrlOut | output | 8 | Control fields, see R5 |

## Verification
A wrong internal state always shows at the outputs as one frame that lands wrongly, and it shows a few system clocks after `ceIn` falls, never before. Examples are a miscounted bit position, an address match that lets through a bad transfer, or a staging flag not cleared at the start of a frame. Each of these moves or corrupts a whole 52-bit slice or the control byte. The stimulus therefore compares the complete image after each transfer. It mixes full, partial, truncated, out-of-order and wrongly addressed frames under both clock idle levels, so that most bad states are visible after a single frame.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_SKIP
  } rxState_e;

  // strobes from the serial control to the word datapath
  typedef struct packed {
    logic frameStart;
    logic shiftBit;
    logic bitVal;
    logic wordEnd;
    logic commit;
  } rxStrobe_t;

endpackage

// File: rtl/seg_rx_ctrl.sv
module seg_rx_ctrl
  import seg_rx_pkg::*;
#(
  parameter int ADDR_BITS = 8,
  parameter logic [ADDR_BITS-1:0] DEV_ADDR = 8'h41,
  parameter int WORD_BITS = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ceIn,
  input  logic      sclkIn,
  input  logic      sdIn,
  output rxStrobe_t strobe,
  output logic      ceLvl
);

  localparam int CNT_W  = $clog2(WORD_BITS);
  localparam int ACNT_W = $clog2(ADDR_BITS);

  logic ceMeta, cePrev;
  logic clkMeta, clkLvl, clkPrev;
  logic sdMeta, sdLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceMeta  <= 1'b0;
      ceLvl   <= 1'b0;
      cePrev  <= 1'b0;
      clkMeta <= 1'b0;
      clkLvl  <= 1'b0;
      clkPrev <= 1'b0;
      sdMeta  <= 1'b0;
      sdLvl   <= 1'b0;
    end else begin
      ceMeta  <= ceIn;
      ceLvl   <= ceMeta;
      cePrev  <= ceLvl;
      clkMeta <= sclkIn;
      clkLvl  <= clkMeta;
      clkPrev <= clkLvl;
      sdMeta  <= sdIn;
      sdLvl   <= sdMeta;
    end
  end

  logic ceRise, ceFall, sclkRise;
  assign ceRise   = ceLvl & ~cePrev;
  assign ceFall   = ~ceLvl & cePrev;
  // a high idle level at frame start is not an edge because clkPrev tracks it
  assign sclkRise = clkLvl & ~clkPrev & ceLvl & ~ceRise;

  rxState_e             state;
  logic [ADDR_BITS-1:0] addrSr;
  logic [ADDR_BITS-1:0] addrNext;
  logic [ACNT_W-1:0]    addrCnt;
  logic [CNT_W-1:0]     bitCnt;

  assign addrNext = {sdLvl, addrSr[ADDR_BITS-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      addrSr  <= '0;
      addrCnt <= '0;
      bitCnt  <= '0;
    end else if (ceRise) begin
      state   <= RX_ADDR;
      addrCnt <= '0;
      bitCnt  <= '0;
    end else if (ceFall) begin
      state <= RX_IDLE;
    end else if (sclkRise) begin
      unique case (state)
        RX_ADDR: begin
          addrSr  <= addrNext;
          addrCnt <= addrCnt + 1'b1;
          if (addrCnt == ACNT_W'(ADDR_BITS - 1))
            state <= (addrNext == DEV_ADDR) ? RX_DATA : RX_SKIP;
        end
        RX_DATA: begin
          if (bitCnt == CNT_W'(WORD_BITS - 1)) bitCnt <= '0;
          else                                 bitCnt <= bitCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.frameStart = ceRise;
    strobe.bitVal     = sdLvl;
    strobe.shiftBit   = sclkRise && (state == RX_DATA);
    strobe.wordEnd    = strobe.shiftBit && (bitCnt == CNT_W'(WORD_BITS - 1));
    strobe.commit     = ceFall && (state == RX_DATA);
  end

endmodule

// File: rtl/seg_rx_data.sv
module seg_rx_data
  import seg_rx_pkg::*;
#(
  parameter int WORD_BITS  = 64,
  parameter int SLICE_BITS = 52,
  parameter int NUM_WORDS  = 4,
  parameter int DISP_BITS  = 204,
  parameter int CTRL_BITS  = 8,
  parameter int CTRL_LSB   = 52,
  parameter logic [CTRL_BITS-1:0] CTRL_RST = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  output logic [DISP_BITS-1:0] dispOut,
  output logic [CTRL_BITS-1:0] ctrlOut
);

  localparam int IDX_W = $clog2(NUM_WORDS);

  logic [WORD_BITS-1:0] shiftReg;
  logic [WORD_BITS-1:0] fullWord;
  logic [WORD_BITS-1:0] unusedWordPad;
  logic [IDX_W-1:0]     wordIdx;
  logic                 stageVld [NUM_WORDS];
  logic [CTRL_BITS-1:0] stageCtrl;
  logic                 commitOk;

  assign fullWord      = {strobe.bitVal, shiftReg[WORD_BITS-1:1]};
  assign unusedWordPad = fullWord;
  assign wordIdx       = fullWord[WORD_BITS-1 -: IDX_W];
  // a frame without word 0 may not touch anything
  assign commitOk      = strobe.commit && stageVld[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= fullWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCtrl <= CTRL_RST;
      ctrlOut   <= CTRL_RST;
    end else begin
      if (strobe.wordEnd && wordIdx == '0)
        stageCtrl <= fullWord[CTRL_LSB +: CTRL_BITS];
      if (commitOk)
        ctrlOut <= stageCtrl;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_slot
    localparam int LO  = w * SLICE_BITS;
    localparam int WID = (DISP_BITS - LO < SLICE_BITS) ? DISP_BITS - LO : SLICE_BITS;

    logic [WID-1:0] stageQ;
    logic [WID-1:0] sliceQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageVld[w] <= 1'b0;
        stageQ      <= '0;
      end else if (strobe.frameStart) begin
        stageVld[w] <= 1'b0;
      end else if (strobe.wordEnd && wordIdx == IDX_W'(w)) begin
        stageVld[w] <= 1'b1;
        stageQ      <= fullWord[WID-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sliceQ <= '0;
      else if (commitOk && stageVld[w]) sliceQ <= stageQ;
    end

    assign dispOut[LO +: WID] = sliceQ;
  end

endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
  import seg_rx_pkg::*;
#(
  parameter int ADDR_BITS  = 8,
  parameter logic [ADDR_BITS-1:0] DEV_ADDR = 8'h41,
  parameter int WORD_BITS  = 64,
  parameter int SLICE_BITS = 52,
  parameter int NUM_WORDS  = 4,
  parameter int DISP_BITS  = 204,
  parameter int CTRL_BITS  = 8,
  parameter int CTRL_LSB   = 52,
  parameter logic [CTRL_BITS-1:0] CTRL_RST = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceIn,
  input  logic                 sclkIn,
  input  logic                 sdIn,
  output logic [DISP_BITS-1:0] dispOut,
  output logic [CTRL_BITS-1:0] ctrlOut
);

  rxStrobe_t strobe;
  logic      ceLvl;

  seg_rx_ctrl #(
    .ADDR_BITS(ADDR_BITS),
    .DEV_ADDR (DEV_ADDR),
    .WORD_BITS(WORD_BITS)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ceIn  (ceIn),
    .sclkIn(sclkIn),
    .sdIn  (sdIn),
    .strobe(strobe),
    .ceLvl (ceLvl)
  );

  seg_rx_data #(
    .WORD_BITS (WORD_BITS),
    .SLICE_BITS(SLICE_BITS),
    .NUM_WORDS (NUM_WORDS),
    .DISP_BITS (DISP_BITS),
    .CTRL_BITS (CTRL_BITS),
    .CTRL_LSB  (CTRL_LSB),
    .CTRL_RST  (CTRL_RST)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dispOut(dispOut),
    .ctrlOut(ctrlOut)
  );

endmodule

// File: rtl/seg_frame_rx_chk.sv
module seg_frame_rx_chk
  import seg_rx_pkg::*;
#(
  parameter int DISP_BITS = 204,
  parameter int CTRL_BITS = 8,
  parameter logic [CTRL_BITS-1:0] CTRL_RST = 8'hC0
) (
  input logic                 clk,
  input logic                 rstN,
  input rxStrobe_t            strobe,
  input logic                 ceLvl,
  input logic [DISP_BITS-1:0] dispOut,
  input logic [CTRL_BITS-1:0] ctrlOut
);

  // first cycle out of reset shows the safe control value
  assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> ctrlOut == CTRL_RST);

  // serial bits are only taken inside a frame
  assert_shift_in_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftBit |-> ceLvl);

  // the commit strobe comes only from a falling frame select
  assert_commit_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (!ceLvl && $past(ceLvl)));

  assert_disp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(dispOut));

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(ctrlOut));

endmodule

bind seg_frame_rx seg_frame_rx_chk #(
  .DISP_BITS(DISP_BITS),
  .CTRL_BITS(CTRL_BITS),
  .CTRL_RST (CTRL_RST)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .strobe (strobe),
  .ceLvl  (ceLvl),
  .dispOut(dispOut),
  .ctrlOut(ctrlOut)
);

// File: tb/seg_frame_rx_tb.sv
module seg_frame_rx_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ceIn = 1'b0;
  logic         sclkIn = 1'b0;
  logic         sdIn = 1'b0;
  logic [203:0] dispOut;
  logic [7:0]   ctrlOut;

  always #5 clk = ~clk;

  seg_frame_rx u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .ceIn   (ceIn),
    .sclkIn (sclkIn),
    .sdIn   (sdIn),
    .dispOut(dispOut),
    .ctrlOut(ctrlOut)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [2:0]  nWords;
    logic [7:0]  order;    // index of word i at [2i+1:2i]
    logic [5:0]  extra;    // bits of a cut-off trailing word
    logic        idleHigh;
    logic [15:0] seed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h41, 3'd4, 8'hE4, 6'd0,  1'b0, 16'hA5C3}, // R4 R5 full image
    '{8'h41, 3'd1, 8'hE4, 6'd0,  1'b1, 16'h1234}, // R9 R3 first word only
    '{8'h42, 3'd4, 8'hE4, 6'd0,  1'b0, 16'hFFFF}, // R2 wrong address
    '{8'hC1, 3'd4, 8'hE4, 6'd0,  1'b1, 16'h0F0F}, // R2 top address bit wrong
    '{8'h41, 3'd2, 8'hE4, 6'd20, 1'b0, 16'h3C3C}, // R7 cut third word
    '{8'h41, 3'd1, 8'hE6, 6'd0,  1'b1, 16'h7777}, // R8 only index 2
    '{8'h41, 3'd0, 8'hE4, 6'd63, 1'b0, 16'h8001}, // R7 R8 63 bits only
    '{8'h41, 3'd3, 8'h23, 6'd0,  1'b1, 16'h5AA5}, // R10 order 3,0,2
    '{8'h41, 3'd4, 8'hE4, 6'd0,  1'b1, 16'h0000}, // R5 control all clear
    '{8'h41, 3'd2, 8'h00, 6'd0,  1'b0, 16'hC0DE}  // R10 repeated index
  };

  int checks = 0;
  int fails  = 0;
  logic [203:0] expDisp = '0;
  logic [7:0]   expCtrl = 8'hC0;

  function automatic logic [63:0] mkWord(logic [15:0] seed, logic [1:0] idx);
    logic [63:0] w;
    w[51:0]  = {seed, seed, seed, seed[3:0]} ^ {13{idx, idx}};
    w[59:52] = seed[7:0] ^ {4{idx}};
    w[61:60] = 2'b11;
    w[63:62] = idx;
    return w;
  endfunction

  task automatic chk(string req, logic [203:0] act, logic [203:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic endFrame();
    repeat (4) @(negedge clk);
    ceIn = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [511:0] bits, input int n,
                           input logic idleHigh, input logic keepCe);
    @(negedge clk);
    sclkIn = idleHigh;
    repeat (4) @(negedge clk);
    ceIn = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (idleHigh) begin
        sclkIn = 1'b0; sdIn = bits[i];
        repeat (4) @(negedge clk);
        sclkIn = 1'b1;
        repeat (4) @(negedge clk);
      end else begin
        sdIn = bits[i];
        repeat (4) @(negedge clk);
        sclkIn = 1'b1;
        repeat (4) @(negedge clk);
        sclkIn = 1'b0;
      end
    end
    if (!keepCe) endFrame();
  endtask

  task automatic buildFrame(input vec_t v, output logic [511:0] bits, output int n);
    logic [63:0] w;
    bits = '0;
    n = 0;
    for (int i = 0; i < 8; i++) begin bits[n] = v.addr[i]; n++; end
    for (int i = 0; i < int'(v.nWords); i++) begin
      w = mkWord(v.seed, v.order[2*i +: 2]);
      for (int k = 0; k < 64; k++) begin bits[n] = w[k]; n++; end
    end
    w = mkWord(v.seed ^ 16'h5A5A, 2'd2);
    for (int k = 0; k < int'(v.extra); k++) begin bits[n] = w[k]; n++; end
  endtask

  task automatic model(input vec_t v);
    logic        have0;
    logic [1:0]  idx;
    logic [63:0] w;
    have0 = 1'b0;
    for (int i = 0; i < int'(v.nWords); i++)
      if (v.order[2*i +: 2] == 2'd0) have0 = 1'b1;
    if (v.addr == 8'h41 && have0) begin
      for (int i = 0; i < int'(v.nWords); i++) begin
        idx = v.order[2*i +: 2];
        w = mkWord(v.seed, idx);
        if (idx == 2'd0) expCtrl = w[59:52];
        for (int k = 0; k < 52; k++)
          if (int'(idx) * 52 + k < 204) expDisp[int'(idx) * 52 + k] = w[k];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [511:0] bits;
    int           n;
    repeat (5) @(negedge clk);
    // R1 reset values
    chk("R1 disp after reset", dispOut, '0);
    chk("R1 ctrl after reset", {196'd0, ctrlOut}, {196'd0, 8'hC0});
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      buildFrame(VECS[v], bits, n);
      sendFrame(bits, n, VECS[v].idleHigh, 1'b0);
      model(VECS[v]);
      chk($sformatf("R2 R4 R7 R8 R9 R10 disp vec%0d", v), dispOut, expDisp);
      chk($sformatf("R2 R5 R8 ctrl vec%0d", v), {196'd0, ctrlOut}, {196'd0, expCtrl});
    end

    // R6: a complete frame is held back until the frame select drops
    buildFrame(VECS[0], bits, n);
    sendFrame(bits, n, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk("R6 disp before ce fall", dispOut, expDisp);
    chk("R6 ctrl before ce fall", {196'd0, ctrlOut}, {196'd0, expCtrl});
    endFrame();
    model(VECS[0]);
    chk("R6 disp after ce fall", dispOut, expDisp);
    chk("R6 ctrl after ce fall", {196'd0, ctrlOut}, {196'd0, expCtrl});

    // R1 reset in the middle of operation restores safe values
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 disp after second reset", dispOut, '0);
    chk("R1 ctrl after second reset", {196'd0, ctrlOut}, {196'd0, 8'hC0});
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule